// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR-flash bus and turns one request into a complete embedded-algorithm transaction. The request is a word program, a sector erase or a chip erase, together with a target address and data. The sequencer first drives the unlock and command write cycles. It shapes every write-enable pulse in system clocks so that each pulse meets the device's minimum widths. It then reads the target address repeatedly until the device signals that the operation has finished. It reports a one-cycle `done` pulse, with `error` raised when the operation did not finish in time.

The device signals completion in two ways, and the sequencer accepts either. In the first, bit 6 stops flipping between two consecutive reads. In the second, bit 7 of a read equals the expected final value: the written data bit 7 for a program, or 1 for an erase. If neither appears within `MAX_POLLS` reads, the sequencer writes a reset command (F0h at address 0) and then finishes with `error` set. The host data drivers are enabled only during write cycles.

States and transitions:
- IDLE goes to WR_SETUP on a valid start.
- WR_SETUP goes to WR_LOW after one cycle.
- WR_LOW goes to WR_HIGH when the pulse timer expires.
- WR_HIGH goes to WR_SETUP for the next command cycle. After the last cycle it goes to RD_LOW, or to DONE if that cycle was the reset write.
- RD_LOW goes to EVAL after the read-cycle time.
- EVAL goes to DONE on completion, to WR_SETUP (reset write) on timeout, and otherwise to RD_GAP.
- RD_GAP goes to RD_LOW after the output-enable high time.
- DONE goes to IDLE.

Top module: `nor_pe_sequencer`

## Requirements
- R1: After reset `ce_n`, `we_n` and `oe_n` are 1, and `dq_oe`, `busy` and `done` are 0.
- R2: Op code 2'b00 (program) issues four write cycles: AAh@555h, 55h@2AAh, A0h@555h, then the request data at the request address.
- R3: Op code 2'b01 (sector erase) issues six write cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@request address.
- R4: Op code 2'b10 (chip erase) issues the same six cycles as R3, except that the last one is 10h@555h.
- R5: Each `we_n` low pulse lasts at least ceil(T_WP/Tclk) clocks (5 by default). `we_n` stays high at least ceil(T_WPH/Tclk) clocks (3 by default) between pulses of one request. Consecutive falling edges are at least ceil(T_WC/Tclk) clocks (10 by default) apart.
- R6: `addr` and `dq_out` do not change while `we_n` is low.
- R7: Each poll holds `oe_n` low at least ceil(T_RC/Tclk) clocks (10 by default). Between polls `oe_n` is high at least ceil(T_OEPH/Tclk) clocks (2 by default). Polls read the request address.
- R8: When bit 6 of a poll equals bit 6 of the previous poll, the request finishes on that poll with `error`=0.
- R9: When bit 7 of a poll equals the expected bit (data bit 7 for a program, 1 for an erase), the request finishes on that poll with `error`=0, including on the first poll.
- R10: After `MAX_POLLS` polls without completion, one write of F0h at address 0 follows, then `done` with `error`=1.
- R11: `dq_oe` is 1 only in write cycles and never while `oe_n` is 0; `we_n` and `oe_n` are never low together.
- R12: `start` is ignored while `busy` is 1 and when op code is 2'b11; `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken in IDLE |
| op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 none |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with `done`: timeout occurred |
| ce_n | output | 1 | Flash chip enable, active low |
| oe_n | output | 1 | Flash output enable, active low |
| we_n | output | 1 | Flash write enable, active low |
| addr | output | AW | Flash address |
| dq_out | output | DW | Data driven to the flash |
| dq_oe | output | 1 | Host data driver enable |
| dq_in | input | DW | Data read from the flash |

## Verification
The bench uses a behavioural flash model. The model flips bit 6 for a chosen number of polls and then either returns the final data or freezes bit 6 while bit 7 stays wrong. This separates toggle-based completion from data-polling completion and shows any design that relies on only one of them, or that stops one poll late or early. A poll with a zero busy count checks that bit 7 can end the request on the very first read, while bit 6 needs a second read. A never-finishing case checks that a design with an off-by-one timeout, or no F0h recovery write, shows a wrong poll count or a missing write. Strobe widths, address and data stability under a low write pulse, and a start pulse arriving mid-request are measured at the pins. Short pulses or a restarted sequence would appear as timing violations or extra writes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_NONE = 2'b11
    } nor_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SETUP,
        S_WR_LOW,
        S_WR_HIGH,
        S_RD_LOW,
        S_RD_GAP,
        S_EVAL,
        S_DONE
    } seq_state_e;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;
    logic [TW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
    assign expired = (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_inc[TW-1:0];
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && expired) |=> (cnt_q == $past(cnt_q))) else $error("timer ran past limit"); // R5

endmodule

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
    import nor_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  nor_op_e       op,
    input  logic [2:0]    step,
    input  logic          abort,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_data,
    output logic          last
);
    localparam logic [AW-1:0] UNLOCK_A = AW'(20'h00555);
    localparam logic [AW-1:0] UNLOCK_B = AW'(20'h002AA);

    always_comb begin
        cyc_addr = UNLOCK_A;
        cyc_data = DW'(8'hAA);
        last     = 1'b0;
        if (abort) begin
            cyc_addr = '0;
            cyc_data = DW'(8'hF0);
            last     = 1'b1;
        end else begin
            unique case (step)
                3'd0: begin cyc_addr = UNLOCK_A; cyc_data = DW'(8'hAA); end
                3'd1: begin cyc_addr = UNLOCK_B; cyc_data = DW'(8'h55); end
                3'd2: begin
                    cyc_addr = UNLOCK_A;
                    cyc_data = (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
                end
                3'd3: begin
                    if (op == OP_PROG) begin
                        cyc_addr = tgt_addr;
                        cyc_data = tgt_data;
                        last     = 1'b1;
                    end else begin
                        cyc_addr = UNLOCK_A;
                        cyc_data = DW'(8'hAA);
                    end
                end
                3'd4: begin cyc_addr = UNLOCK_B; cyc_data = DW'(8'h55); end
                default: begin
                    last = 1'b1;
                    if (op == OP_SECT) begin
                        cyc_addr = tgt_addr;
                        cyc_data = DW'(8'h30);
                    end else begin
                        cyc_addr = UNLOCK_A;
                        cyc_data = DW'(8'h10);
                    end
                end
            endcase
        end
    end

    always_comb begin
        AST_LAST_STEP: assert (!last || abort || step == 3'd3 || step >= 3'd5) else $error("early last"); // R2
    end

endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval (
    input  logic cur_b7,
    input  logic cur_b6,
    input  logic prev_b6,
    input  logic have_prev,
    input  logic expect_b7,
    output logic toggle_stop,
    output logic data_match,
    output logic complete
);
    assign toggle_stop = have_prev && (cur_b6 == prev_b6);
    assign data_match  = (cur_b7 == expect_b7);
    assign complete    = toggle_stop || data_match;
endmodule

// File: rtl/nor_pe_sequencer.sv
module nor_pe_sequencer
    import nor_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int CLK_PS     = 10000,
    parameter int T_WP_NS    = 50,
    parameter int T_WPH_NS   = 30,
    parameter int T_WC_NS    = 100,
    parameter int T_RC_NS    = 100,
    parameter int T_OEPH_NS  = 20,
    parameter int MAX_POLLS  = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_in
);
    localparam int WP_CYC   = ns_to_cyc(T_WP_NS, CLK_PS);
    localparam int WPH_CYC  = ns_to_cyc(T_WPH_NS, CLK_PS);
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PS);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PS);
    localparam int OEPH_CYC = ns_to_cyc(T_OEPH_NS, CLK_PS);
    localparam int WH_CYC   = (WC_CYC > WP_CYC + 1 + WPH_CYC) ? (WC_CYC - WP_CYC - 1) : WPH_CYC;
    localparam int TW       = $clog2(WP_CYC + WH_CYC + RC_CYC + OEPH_CYC + 2);
    localparam int PCW      = $clog2(MAX_POLLS + 1);

    seq_state_e    state_q, state_d;
    nor_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [2:0]    step_q;
    logic          abort_q;
    logic          err_q;
    logic [PCW-1:0] poll_q;
    logic [DW-1:0] rd_q;
    logic          prev6_q;
    logic          have_prev_q;

    logic          restart, expired;
    logic [TW-1:0] limit;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;
    logic          cyc_last;
    logic          complete, toggle_stop, data_match;
    logic          expect7;
    logic          start_ok;
    logic          timeout;

    assign start_ok = start && (nor_op_e'(op) != OP_NONE);
    assign expect7  = (op_q == OP_PROG) ? data_q[7] : 1'b1;
    assign timeout  = (poll_q >= PCW'(MAX_POLLS));

    nor_cmd_table #(.AW(AW), .DW(DW)) u_cmd (
        .op(op_q), .step(step_q), .abort(abort_q),
        .tgt_addr(addr_q), .tgt_data(data_q),
        .cyc_addr(cyc_addr), .cyc_data(cyc_data), .last(cyc_last)
    );

    nor_poll_eval u_eval (
        .cur_b7(rd_q[7]), .cur_b6(rd_q[6]), .prev_b6(prev6_q),
        .have_prev(have_prev_q), .expect_b7(expect7),
        .toggle_stop(toggle_stop), .data_match(data_match), .complete(complete)
    );

    nor_phase_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .expired(expired)
    );

    always_comb begin
        unique case (state_q)
            S_WR_LOW:  limit = TW'(WP_CYC);
            S_WR_HIGH: limit = TW'(WH_CYC);
            S_RD_LOW:  limit = TW'(RC_CYC);
            S_RD_GAP:  limit = TW'(OEPH_CYC);
            default:   limit = TW'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_ok) state_d = S_WR_SETUP;
            S_WR_SETUP: if (expired) state_d = S_WR_LOW;
            S_WR_LOW:   if (expired) state_d = S_WR_HIGH;
            S_WR_HIGH:  if (expired) begin
                if (!cyc_last)    state_d = S_WR_SETUP;
                else if (abort_q) state_d = S_DONE;
                else              state_d = S_RD_LOW;
            end
            S_RD_LOW:   if (expired) state_d = S_EVAL;
            S_EVAL: begin
                if (complete)     state_d = S_DONE;
                else if (timeout) state_d = S_WR_SETUP;
                else              state_d = S_RD_GAP;
            end
            S_RD_GAP:   if (expired) state_d = S_RD_LOW;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    assign restart = (state_d != state_q);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            op_q        <= OP_NONE;
            addr_q      <= '0;
            data_q      <= '0;
            step_q      <= '0;
            abort_q     <= 1'b0;
            err_q       <= 1'b0;
            poll_q      <= '0;
            rd_q        <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (start_ok) begin
                    op_q        <= nor_op_e'(op);
                    addr_q      <= req_addr;
                    data_q      <= req_data;
                    step_q      <= '0;
                    abort_q     <= 1'b0;
                    err_q       <= 1'b0;
                    poll_q      <= '0;
                    have_prev_q <= 1'b0;
                end
                S_WR_HIGH: if (expired && !cyc_last) step_q <= step_q + 3'd1;
                S_RD_LOW: if (expired) begin
                    rd_q   <= dq_in;
                    poll_q <= poll_q + PCW'(1);
                end
                S_EVAL: begin
                    prev6_q     <= rd_q[6];
                    have_prev_q <= 1'b1;
                    if (!complete && timeout) begin
                        abort_q <= 1'b1;
                        err_q   <= 1'b1;
                        step_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ce_n   = 1'b0;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        dq_oe  = 1'b0;
        addr   = addr_q;
        dq_out = '0;
        busy   = 1'b1;
        done   = 1'b0;
        error  = 1'b0;
        unique case (state_q)
            S_IDLE: begin ce_n = 1'b1; busy = 1'b0; end
            S_WR_SETUP, S_WR_HIGH: begin
                dq_oe = 1'b1; addr = cyc_addr; dq_out = cyc_data;
            end
            S_WR_LOW: begin
                we_n = 1'b0; dq_oe = 1'b1; addr = cyc_addr; dq_out = cyc_data;
            end
            S_RD_LOW: oe_n = 1'b0;
            S_RD_GAP, S_EVAL: ;
            S_DONE: begin ce_n = 1'b1; done = 1'b1; error = err_q; end
            default: ;
        endcase
    end

    AST_DQ_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !oe_n)) else $error("bus contention"); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n)) else $error("we and oe both low"); // R11
    AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out))) else $error("bus moved under we"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R12
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_q <= PCW'(MAX_POLLS)) else $error("poll count overflow"); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(op_q) && $stable(addr_q))) else $error("request changed mid-run"); // R12

endmodule

// File: tb/nor_pe_sequencer_bench.sv
module nor_pe_sequencer_bench;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int MAXP = 8;
    localparam int E_WP = 5, E_WPH = 3, E_WC = 10, E_RC = 10, E_OEPH = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] a;
        logic [15:0] d;
        logic [1:0]  mode;   // 0 finish with data, 1 freeze bit6, 2 never finish
        logic [7:0]  k;      // busy polls before finishing
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{op: 2'b00, a: 20'h12345, d: 16'h00A5, mode: 2'd0, k: 8'd3},
        '{op: 2'b00, a: 20'h00010, d: 16'h0055, mode: 2'd0, k: 8'd0},
        '{op: 2'b01, a: 20'h40000, d: 16'h0000, mode: 2'd0, k: 8'd5},
        '{op: 2'b10, a: 20'h00000, d: 16'h0000, mode: 2'd1, k: 8'd4},
        '{op: 2'b01, a: 20'hF0000, d: 16'h0000, mode: 2'd1, k: 8'd0},
        '{op: 2'b00, a: 20'h0ABCD, d: 16'h1234, mode: 2'd2, k: 8'd0}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [1:0] op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_data = 0;
    logic busy, done, error, ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_in = 0;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    nor_pe_sequencer #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u_nor_pe_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .error(error), .ce_n(ce_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // flash model and monitors
    logic mon_en = 0;
    logic [1:0] m_mode; logic [7:0] m_left; logic m_t6, m_exp7; logic [15:0] m_final;
    logic [AW-1:0] wr_a [16];
    logic [DW-1:0] wr_d [16];
    int wcnt = 0, rcnt = 0, bad_raddr = 0;

    always @(posedge we_n) if (mon_en && rst_n) begin
        if (wcnt < 16) begin wr_a[wcnt] = addr; wr_d[wcnt] = dq_out; end
        wcnt++;
    end

    always @(negedge oe_n) if (mon_en && rst_n) begin
        rcnt++;
        if (addr != req_addr) bad_raddr++;
        if (m_mode == 2'd2 || m_left != 0) begin
            m_t6 = ~m_t6;
            if (m_left != 0) m_left--;
            dq_in = 16'h0; dq_in[7] = ~m_exp7; dq_in[6] = m_t6;
        end else if (m_mode == 2'd0) begin
            dq_in = m_final;
        end else begin
            dq_in = 16'h0; dq_in[7] = ~m_exp7; dq_in[6] = m_t6;
        end
    end

    int v5 = 0, v6 = 0, v7 = 0, v11 = 0;
    int we_lo = 0, we_hi = 0, we_per = 0, oe_lo = 0, oe_hi = 0;
    logic seen_we = 0, seen_oe = 0, p_we = 1, p_oe = 1;
    logic [AW-1:0] p_addr; logic [DW-1:0] p_dq;

    always @(negedge clk) if (mon_en) begin
        if (dq_oe && !oe_n) v11++;
        if (!we_n && !oe_n) v11++;
        if (!we_n && !p_we && (addr != p_addr || dq_out != p_dq)) v6++;
        if (ce_n) begin seen_we = 0; seen_oe = 0; end
        if (!we_n && p_we) begin
            if (seen_we && (we_hi < E_WPH || we_per < E_WC)) v5++;
            we_per = 0; we_lo = 0; seen_we = 1;
        end
        if (we_n && !p_we) begin
            if (we_lo < E_WP) v5++;
            we_hi = 0;
        end
        if (!oe_n && p_oe) begin
            if (seen_oe && oe_hi < E_OEPH) v7++;
            oe_lo = 0; seen_oe = 1;
        end
        if (oe_n && !p_oe) begin
            if (oe_lo < E_RC) v7++;
            oe_hi = 0;
        end
        we_per++;
        if (!we_n) we_lo++; else we_hi++;
        if (!oe_n) oe_lo++; else oe_hi++;
        p_we = we_n; p_oe = oe_n; p_addr = addr; p_dq = dq_out;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] exp_wr(input logic [1:0] o, input logic [19:0] a,
                                           input logic [15:0] d, input int i);
        case (i)
            0: return {20'h00555, 16'h00AA};
            1: return {20'h002AA, 16'h0055};
            2: return {20'h00555, (o == 2'b00) ? 16'h00A0 : 16'h0080};
            3: return (o == 2'b00) ? {a, d} : {20'h00555, 16'h00AA};
            4: return {20'h002AA, 16'h0055};
            5: return (o == 2'b01) ? {a, 16'h0030} : {20'h00555, 16'h0010};
            default: return {20'h00000, 16'h00F0};
        endcase
    endfunction

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        if (!ok) begin errors++; checks++; $display("FAIL watchdog: done never seen"); end
    endtask

    task automatic run_vec(input vec_t v, input string rq);
        bit ok; int nw, np; bit ee; logic [35:0] ew;
        m_mode = v.mode; m_left = v.k; m_t6 = 0;
        m_exp7 = (v.op == 2'b00) ? v.d[7] : 1'b1;
        m_final = (v.op == 2'b00) ? v.d : 16'hFFFF;
        wcnt = 0; rcnt = 0; bad_raddr = 0;
        @(negedge clk);
        start = 1; op = v.op; req_addr = v.a; req_data = v.d;
        @(negedge clk);
        start = 0;
        wait_done(ok);
        if (!ok) return;
        nw = (v.op == 2'b00) ? 4 : 6;
        ee = (v.mode == 2'd2);
        if (v.mode == 2'd2)      np = MAXP;
        else if (v.mode == 2'd0) np = v.k + 1;
        else                     np = (v.k + 1 < 2) ? 2 : v.k + 1;
        if (ee) nw++;
        chk(wcnt == nw, {rq, " write count"}, wcnt, nw);
        for (int i = 0; i < nw && i < 16; i++) begin
            ew = exp_wr(v.op, v.a, v.d, (ee && i == nw - 1) ? 9 : i);
            chk({wr_a[i], wr_d[i]} == ew, {rq, " write cycle"}, {wr_a[i], wr_d[i]}, ew);
        end
        chk(rcnt == np, {rq, " poll count"}, rcnt, np);
        chk(error == ee, {rq, " error flag"}, error, ee);
        chk(bad_raddr == 0, "R7 poll address", bad_raddr, 0);
        @(negedge clk);
        chk(done == 0, "R12 done pulse width", done, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string names [NV] = '{"R2 R9 program data-poll", "R2 R9 program first-poll",
                              "R3 R9 sector erase", "R4 R8 chip erase toggle",
                              "R3 R8 sector toggle two reads", "R10 timeout"};
        bit ok; int w0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_n && we_n && oe_n, "R1 strobes high in reset", {ce_n, we_n, oe_n}, 3'b111);
        chk(!dq_oe && !busy && !done, "R1 idle flags", {dq_oe, busy, done}, 0);
        rst_n = 1;
        @(negedge clk);
        mon_en = 1;
        chk(ce_n && we_n && oe_n && !busy, "R1 after release", {ce_n, we_n, oe_n, busy}, 4'b1110);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], names[i]);

        // R12 op 11 ignored
        w0 = wcnt;
        @(negedge clk); start = 1; op = 2'b11; @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        chk(!busy && wcnt == w0 && ce_n, "R12 op 11 ignored", {busy, ce_n}, 2'b01);

        // R12 start while busy ignored
        m_mode = 0; m_left = 2; m_t6 = 0; m_exp7 = 1; m_final = 16'h0080;
        wcnt = 0; rcnt = 0;
        @(negedge clk); start = 1; op = 2'b00; req_addr = 20'h00777; req_data = 16'h0080;
        @(negedge clk); start = 0;
        repeat (15) @(negedge clk);
        start = 1; op = 2'b10; @(negedge clk); start = 0; op = 2'b00;
        wait_done(ok);
        chk(wcnt == 4 && wr_a[3] == 20'h00777, "R12 mid-run start ignored", wcnt, 4);
        chk(rcnt == 3, "R12 mid-run polls", rcnt, 3);

        chk(v5 == 0, "R5 write strobe timing", v5, 0);
        chk(v6 == 0, "R6 bus stable under we", v6, 0);
        chk(v7 == 0, "R7 read strobe timing", v7, 0);
        chk(v11 == 0, "R11 driver exclusion", v11, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule